// File: doc/BRIEF.md
# SPI Bit-Rate Prescaler Solver

This block converts a requested serial clock rate into the two prescaler fields that a SPI clock generator consumes. The generator divides the reference clock first by a coarse power-of-two stage, selected by a 2-bit code `p`, and then by an even fine stage, selected by a 6-bit code `f`. The resulting serial clock is `ref / (2 << p) / (2 * (f + 1))`. The legal fine codes lie between 4 and 63.

A caller presents the reference frequency and the requested rate in hertz and pulses `start_i`. The block forms the integer ratio `ref / rate` with a radix-2 restoring divider, one quotient bit per cycle. It then tries the coarse codes from 0 upward until it finds one whose truncated fine ratio fits the fine window. A request that is too fast is clamped to the fastest legal setting. A request that is too slow is clamped to the slowest legal setting. A requested rate of zero skips the division, raises an error flag and returns the slowest setting.

Top module: `spi_rate_solver`

## Requirements
- R1: Whenever the search accepts a coarse code without clamping, the product `rate * (4 << p) * (f + 1)` does not exceed `ref`, so the achieved serial clock is never slower than requested.
- R2: At every done pulse, `fine_sel_o` lies in 4..63 and `pre_sel_o` lies in 0..3.
- R3: With `q = floor(ref / rate)` and `t(p) = floor(q / (4 << p))`, the result is the lowest `p` for which `t(p) <= 64`, with `f = t(p) - 1` when `t(p) >= 5`.
- R4: When the first code tried already gives `t(p) < 5`, including the case `ref < rate`, the result is `p = 0` and `f = 4`.
- R5: When `t(p) > 64` for every `p` from 0 to 3, the result is `p = 3` and `f = 63`.
- R6: `done_o` is high for exactly one cycle per accepted request. The result outputs keep their values between done pulses.
- R7: `busy_o` is high from the cycle after an accepted nonzero request until its done pulse. A `start_i` pulse seen while `busy_o` is high is ignored and does not change the result.
- R8: A request with `rate_hz_i = 0` gives `done_o` on the next cycle without raising `busy_o`. It sets `zero_err_o` and returns `p = 3` and `f = 63`. The next nonzero request clears `zero_err_o`.
- R9: With the default parameters, `done_o` rises no later than 40 cycles after the clock edge that accepts a nonzero request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Request strobe, accepted only while idle |
| ref_hz_i | input | 32 | Reference clock frequency in Hz |
| rate_hz_i | input | 32 | Requested serial clock rate in Hz |
| busy_o | output | 1 | Computation in progress |
| done_o | output | 1 | One-cycle result-valid pulse |
| zero_err_o | output | 1 | Last request had a zero rate |
| pre_sel_o | output | 2 | Coarse power-of-two divider code |
| fine_sel_o | output | 6 | Fine divider code |

## Verification
On every cycle, the assertions check the one-cycle width of the done pulse and that the result outputs stay frozen while a computation runs. They also check the fine-code floor at each result, that a zero-rate result carries the slowest setting, and that the divider's final remainder is below the divisor. Only the bench scenarios can show that the chosen coarse code is the lowest acceptable one. The same holds for the exact clamp points at truncated ratios 4, 5, 64 and 65, the latency bound, and the dropping of a second request made mid-computation. The bench compares each of these against a reference function of its own.

// File: rtl/spi_rate_pkg.sv
package spi_rate_pkg;

   typedef enum logic {
      ST_IDLE = 1'b0,
      ST_RUN  = 1'b1
   } srs_state_e;

   localparam int unsigned SRS_DATA_W   = 32;
   localparam int unsigned SRS_PRE_W    = 2;
   localparam int unsigned SRS_FINE_W   = 6;
   localparam int unsigned SRS_FINE_MIN = 4;

endpackage

// File: rtl/srs_divider.sv
module srs_divider #(
   parameter int unsigned W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         go_i,
   input  logic [W-1:0] num_i,
   input  logic [W-1:0] den_i,
   output logic         fin_o,
   output logic [W-1:0] quo_o
);
   localparam int unsigned CW = $clog2(W + 1);

   logic [W-1:0]  rem_r, quo_r, den_r;
   logic [CW-1:0] cnt_r;
   logic [W:0]    diff;
   logic          ge;
   logic [W-1:0]  rem_n;

   // trial subtraction of the divisor from the shifted partial remainder
   assign diff  = {rem_r, quo_r[W-1]} - {1'b0, den_r};
   assign ge    = ~diff[W];
   assign rem_n = ge ? diff[W-1:0] : {rem_r[W-2:0], quo_r[W-1]};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rem_r <= '0;
         quo_r <= '0;
         den_r <= '0;
         cnt_r <= '0;
         fin_o <= 1'b0;
      end else if (go_i) begin
         rem_r <= '0;
         quo_r <= num_i;
         den_r <= den_i;
         cnt_r <= CW'(W);
         fin_o <= 1'b0;
      end else if (cnt_r != '0) begin
         rem_r <= rem_n;
         quo_r <= {quo_r[W-2:0], ge};
         cnt_r <= cnt_r - 1'b1;
         fin_o <= (cnt_r == CW'(1));
      end else begin
         fin_o <= 1'b0;
      end
   end

   assign quo_o = quo_r;

   // R3: the quotient is exact, so the remainder left over is below the divisor
   p_rem_below_den_r3: assert property (@(posedge clk) disable iff (!rst_n)
      fin_o |-> (rem_r < den_r));

endmodule

// File: rtl/srs_pick.sv
module srs_pick #(
   parameter int unsigned DATA_W   = 32,
   parameter int unsigned PRE_W    = 2,
   parameter int unsigned FINE_W   = 6,
   parameter int unsigned FINE_MIN = 4,
   parameter bit          SERIAL   = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              go_i,
   input  logic [DATA_W-1:0] quot_i,
   output logic              fin_o,
   output logic [PRE_W-1:0]  pre_o,
   output logic [FINE_W-1:0] fine_o
);
   localparam int unsigned NUM_PRE  = 1 << PRE_W;
   localparam int unsigned FINE_MAX = (1 << FINE_W) - 1;
   localparam logic [DATA_W-1:0] LOW_LIM  = DATA_W'(FINE_MIN + 1);
   localparam logic [DATA_W-1:0] HIGH_LIM = DATA_W'(FINE_MAX + 1);

   logic              fire;
   logic [PRE_W-1:0]  pre_n;
   logic [FINE_W-1:0] fine_n;

   function automatic logic [FINE_W-1:0] fine_of(input logic [DATA_W-1:0] t);
      if (t < LOW_LIM) return FINE_W'(FINE_MIN);
      return FINE_W'(t - DATA_W'(1));
   endfunction

   generate
      if (SERIAL) begin : g_serial
         logic [DATA_W-1:0] q_r, t_s;
         logic [PRE_W-1:0]  idx_r;
         logic              act_r, hit, last;

         assign t_s    = q_r >> (32'(idx_r) + 32'd2);
         assign hit    = (t_s <= HIGH_LIM);
         assign last   = (idx_r == PRE_W'(NUM_PRE - 1));
         assign fire   = act_r && (hit || last);
         assign pre_n  = idx_r;
         assign fine_n = hit ? fine_of(t_s) : FINE_W'(FINE_MAX);

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               q_r   <= '0;
               idx_r <= '0;
               act_r <= 1'b0;
            end else if (go_i) begin
               q_r   <= quot_i;
               idx_r <= '0;
               act_r <= 1'b1;
            end else if (act_r) begin
               if (hit || last) act_r <= 1'b0;
               else             idx_r <= idx_r + 1'b1;
            end
         end

         // R3: a candidate code is only tried while a search is active
         p_idx_held_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
            !act_r && !go_i |=> $stable(idx_r));
      end else begin : g_parallel
         logic [DATA_W-1:0] t_c [NUM_PRE];

         for (genvar g = 0; g < NUM_PRE; g++) begin : g_cand
            assign t_c[g] = quot_i >> (g + 2);
         end

         always_comb begin
            logic found;
            found  = 1'b0;
            pre_n  = PRE_W'(NUM_PRE - 1);
            fine_n = FINE_W'(FINE_MAX);
            for (int i = 0; i < NUM_PRE; i++) begin
               if (!found && (t_c[i] <= HIGH_LIM)) begin
                  found  = 1'b1;
                  pre_n  = PRE_W'(i);
                  fine_n = fine_of(t_c[i]);
               end
            end
         end
         assign fire = go_i;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         fin_o  <= 1'b0;
         pre_o  <= '0;
         fine_o <= '0;
      end else begin
         fin_o <= fire;
         if (fire) begin
            pre_o  <= pre_n;
            fine_o <= fine_n;
         end
      end
   end

   // R2: every produced fine code respects the lower bound of the window
   p_fine_floor_r2: assert property (@(posedge clk) disable iff (!rst_n)
      fin_o |-> (fine_o >= FINE_W'(FINE_MIN)));

endmodule

// File: rtl/spi_rate_solver.sv
module spi_rate_solver
   import spi_rate_pkg::*;
#(
   parameter int unsigned DATA_W   = SRS_DATA_W,
   parameter int unsigned PRE_W    = SRS_PRE_W,
   parameter int unsigned FINE_W   = SRS_FINE_W,
   parameter int unsigned FINE_MIN = SRS_FINE_MIN,
   parameter bit          SERIAL   = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [31:0]       ref_hz_i,
   input  logic [31:0]       rate_hz_i,
   output logic              busy_o,
   output logic              done_o,
   output logic              zero_err_o,
   output logic [1:0]        pre_sel_o,
   output logic [5:0]        fine_sel_o
);
   localparam int unsigned FINE_MAX = (1 << FINE_W) - 1;
   localparam int unsigned NUM_PRE  = 1 << PRE_W;

   initial begin
      a_cfg_width: assert (DATA_W == 32 && PRE_W == 2 && FINE_W == 6)
         else $error("port widths fixed at 32/2/6");
      a_cfg_window: assert (FINE_MIN >= 1 && FINE_MIN < FINE_MAX)
         else $error("fine window empty");
      a_cfg_span: assert (DATA_W > NUM_PRE + 2)
         else $error("data width too small for coarse span");
   end

   srs_state_e        state_q;
   logic              acc_ok, go_div, zero_hit;
   logic              div_fin, pk_fin;
   logic [DATA_W-1:0] quot;
   logic [PRE_W-1:0]  pk_pre;
   logic [FINE_W-1:0] pk_fine;

   assign acc_ok   = start_i && (state_q == ST_IDLE);
   assign go_div   = acc_ok && (rate_hz_i != '0);
   assign zero_hit = acc_ok && (rate_hz_i == '0);

   srs_divider #(.W(DATA_W)) div_i (
      .clk   (clk),
      .rst_n (rst_n),
      .go_i  (go_div),
      .num_i (ref_hz_i),
      .den_i (rate_hz_i),
      .fin_o (div_fin),
      .quo_o (quot)
   );

   srs_pick #(
      .DATA_W   (DATA_W),
      .PRE_W    (PRE_W),
      .FINE_W   (FINE_W),
      .FINE_MIN (FINE_MIN),
      .SERIAL   (SERIAL)
   ) pick_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .go_i   (div_fin),
      .quot_i (quot),
      .fin_o  (pk_fin),
      .pre_o  (pk_pre),
      .fine_o (pk_fine)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q    <= ST_IDLE;
         done_o     <= 1'b0;
         zero_err_o <= 1'b0;
         pre_sel_o  <= '0;
         fine_sel_o <= '0;
      end else begin
         done_o <= 1'b0;
         if (zero_hit) begin
            zero_err_o <= 1'b1;
            pre_sel_o  <= PRE_W'(NUM_PRE - 1);
            fine_sel_o <= FINE_W'(FINE_MAX);
            done_o     <= 1'b1;
         end else if (go_div) begin
            zero_err_o <= 1'b0;
            state_q    <= ST_RUN;
         end else if (state_q == ST_RUN && pk_fin) begin
            pre_sel_o  <= pk_pre;
            fine_sel_o <= pk_fine;
            done_o     <= 1'b1;
            state_q    <= ST_IDLE;
         end
      end
   end

   assign busy_o = (state_q == ST_RUN);

   // R6: the result-valid strobe never lasts two cycles
   p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   // R7: results stay frozen while a computation is running
   p_hold_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(busy_o) && busy_o) |-> ($stable(pre_sel_o) && $stable(fine_sel_o)));

   // R8: a zero-rate result always carries the slowest setting
   p_zero_slow_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && zero_err_o) |-> (pre_sel_o == 2'd3 && fine_sel_o == 6'd63));

   // R7: a start seen while busy leaves the block busy or finishing
   p_start_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && start_i && !pk_fin) |=> busy_o);

endmodule

// File: tb/spi_rate_solver_tb_top.sv
module spi_rate_solver_tb_top;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_i = 1'b0;
   logic [31:0] ref_hz_i = '0;
   logic [31:0] rate_hz_i = '0;
   logic        busy_o, done_o, zero_err_o;
   logic [1:0]  pre_sel_o;
   logic [5:0]  fine_sel_o;

   int n_chk = 0;
   int n_bad = 0;
   int cyc   = 0;

   spi_rate_solver dut_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .start_i    (start_i),
      .ref_hz_i   (ref_hz_i),
      .rate_hz_i  (rate_hz_i),
      .busy_o     (busy_o),
      .done_o     (done_o),
      .zero_err_o (zero_err_o),
      .pre_sel_o  (pre_sel_o),
      .fine_sel_o (fine_sel_o)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > 150000) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: run hung, actual=%0d expected<150000", cyc);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // reference: returns {clamp_kind, pre, fine}; clamp 0 none, 1 fast, 2 slow
   function automatic logic [9:0] ref_model(input logic [31:0] rf, input logic [31:0] rt);
      logic [31:0] q, t;
      if (rt == 0) return {2'd2, 2'd3, 6'd63};
      q = rf / rt;
      for (int d = 0; d < 4; d++) begin
         t = q / (32'd4 << d);
         if (t < 5)   return {2'd1, 2'(d), 6'd4};
         if (t <= 64) return {2'd0, 2'(d), 6'(t - 1)};
      end
      return {2'd2, 2'd3, 6'd63};
   endfunction

   task automatic run_case(input logic [31:0] rf, input logic [31:0] rt, input string req);
      logic [9:0] e;
      int n;
      longint prod;
      e = ref_model(rf, rt);
      @(negedge clk);
      ref_hz_i = rf; rate_hz_i = rt; start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      n = 1;
      while (!done_o && n < 200) begin
         @(negedge clk);
         n++;
      end
      chk(done_o == 1'b1, "R6 done seen", longint'(done_o), 1);
      chk(pre_sel_o == e[7:6], req, longint'(pre_sel_o), longint'(e[7:6]));
      chk(fine_sel_o == e[5:0], req, longint'(fine_sel_o), longint'(e[5:0]));
      chk(fine_sel_o >= 6'd4, "R2 fine window", longint'(fine_sel_o), 4);
      chk(zero_err_o == (rt == 0), "R8 error flag", longint'(zero_err_o), longint'(rt == 0));
      if (rt == 0) begin
         chk(n == 1, "R8 next-cycle done", n, 1);
         chk(busy_o == 1'b0, "R8 no busy", longint'(busy_o), 0);
      end else begin
         chk(n <= 40, "R9 latency", n, 40);
      end
      if (e[9:8] == 2'd0) begin
         prod = longint'(rt) * longint'(4 << pre_sel_o) * longint'(fine_sel_o + 1);
         chk(prod <= longint'(rf), "R1 rate not slower", prod, longint'(rf));
      end
      @(negedge clk);
      chk(done_o == 1'b0, "R6 single-cycle done", longint'(done_o), 0);
   endtask

   initial begin
      logic [31:0] rf, rt, k;
      logic [1:0]  held_p;
      logic [5:0]  held_f;
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      chk(done_o == 0 && busy_o == 0 && zero_err_o == 0, "R6 reset idle",
          longint'({done_o, busy_o, zero_err_o}), 0);
      rst_n = 1'b1;

      // directed corners
      run_case(32'd1000000, 32'd52631, "R4 t=4 fast clamp");
      run_case(32'd1000000, 32'd50000, "R3 t=5 lowest accept");
      run_case(32'd1000000, 32'd3906,  "R3 t=64 at p0");
      run_case(32'd1000000, 32'd3846,  "R3 t=65 moves to p1");
      run_case(32'd2079,    32'd1,     "R3 accept at p3");
      run_case(32'd1000,    32'd5000,  "R4 ref below rate");
      run_case(32'd100000000, 32'd1,   "R5 slow clamp");
      run_case(32'hFFFFFFFF, 32'hFFFFFFFF, "R4 equal maxima");
      run_case(32'd48000000, 32'd0,    "R8 zero rate");
      run_case(32'd48000000, 32'd1000000, "R8 flag cleared R3");

      // R7: second start during computation is dropped, outputs held
      held_p = pre_sel_o; held_f = fine_sel_o;
      @(negedge clk);
      ref_hz_i = 32'd1000000; rate_hz_i = 32'd3846; start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      repeat (3) @(negedge clk);
      chk(busy_o == 1'b1, "R7 busy during run", longint'(busy_o), 1);
      chk(pre_sel_o == held_p && fine_sel_o == held_f, "R6 result held",
          longint'({pre_sel_o, fine_sel_o}), longint'({held_p, held_f}));
      ref_hz_i = 32'd100000000; rate_hz_i = 32'd1; start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      for (int i = 0; i < 200 && !done_o; i++) @(negedge clk);
      chk(pre_sel_o == 2'd1, "R7 ignored start pre", longint'(pre_sel_o), 1);
      chk(fine_sel_o == 6'd31, "R7 ignored start fine", longint'(fine_sel_o), 31);
      @(negedge clk);
      chk(busy_o == 1'b0, "R7 idle after done", longint'(busy_o), 0);

      // constrained random
      for (int i = 0; i < 90; i++) begin
         rf = 32'd1000000 + ($urandom % 32'd199000000);
         case ($urandom % 3)
            0:       k = 1 + ($urandom % 300);
            1:       k = 1 + ($urandom % 3000);
            default: k = 1 + ($urandom % 20000);
         endcase
         rt = rf / k + ($urandom % 5);
         if (rt == 0) rt = 1;
         run_case(rf, rt, "R3 random search");
      end

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule